// File: doc/BRIEF.md
# Multiplexed GPIO Bank Controller

This block manages one bank of general-purpose I/O pins, 32 by default. For each pin it decides who drives the pad. Either the GPIO logic owns the pin, or one of two internal peripheral functions, A or B, does. For each pin it also holds output enable, output data, pull-up enable, open-drain mode and a glitch-filter enable. Software reaches all of this through a single-cycle register bus. Pin number `p` of a chip maps to bank `p/32` and bit `1 << (p%32)` within that bank.

Every stored attribute is changed only through a pair of write-only addresses. One address sets the bits written as 1 and the other clears them. Bits written as 0 are left alone, so no read-modify-write is ever needed. A status address returns the current value of each attribute. A further status address returns the pad level after it has been resynchronised. It returns that level whether or not GPIO owns the pin.

The output data latch can be loaded while the pin is still an input. A pin can therefore be turned into an output already at the intended level. The bus is plain control traffic with no stream, so it has no valid/ready handshake. A write takes effect at the clock edge that samples it, and read data is combinational from the address.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every pin reads as GPIO-owned with pull-up on. Output enable, output data, open-drain, glitch filter and peripheral select (0 means A) all read 0. `pad_pu` is all ones and `pad_oe` is all zeros.
- R2: Each attribute uses three word addresses: set at 3k, clear at 3k+1 and status at 3k+2. The attributes are k=0 ownership, k=1 output enable, k=2 output data, k=3 pull-up, k=4 open-drain and k=5 glitch filter. A write to a set address ORs in the written ones, and a write to a clear address removes them. Bits written as 0 keep their value.
- R3: Peripheral select is k=6. A write to address 18 routes the written pins to B, so they read 1 at status address 20. A write to address 19 routes them back to A, so they read 0.
- R4: For a GPIO-owned pin with open-drain off, `pad_oe` follows the output-enable bit and `pad_out` follows the output-data bit.
- R5: With open-drain on, `pad_out` is 0. `pad_oe` is high only while the source drives a 0 with its enable set, so a 1 leaves the pad released.
- R6: For a pin not owned by GPIO, the drive value and enable come from `pa_out`/`pa_oe` when select is 0 and from `pb_out`/`pb_oe` when select is 1. The GPIO latches are ignored.
- R7: Status address 21 returns `pad_in` for every pin, whoever owns it. A change shows there after the second rising clock edge.
- R8: Output data written while output enable is 0 does not reach the pad. It appears in the same cycle that output enable is set.
- R9: Reads of set, clear or unmapped addresses (22 and up) return 0.
- R10: `pad_pu` mirrors the pull-up bits and `pad_filt` mirrors the glitch-filter bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | NPINS | Write data, one bit per pin |
| bus_rdata | output | NPINS | Read data for bus_addr |
| pad_in | input | NPINS | Pad level from the pads |
| pad_out | output | NPINS | Value driven to each pad |
| pad_oe | output | NPINS | Pad driver enable |
| pad_pu | output | NPINS | Pull-up enable per pad |
| pad_filt | output | NPINS | Glitch-filter enable per pad |
| pa_out | input | NPINS | Peripheral A drive value |
| pa_oe | input | NPINS | Peripheral A drive enable |
| pb_out | input | NPINS | Peripheral B drive value |
| pb_oe | input | NPINS | Peripheral B drive enable |

## Verification
The hardest case to reach is a pin handed to a peripheral while its GPIO latches still hold opposite values. From the ports it looks exactly like a correct mux unless those latches disagree with the peripheral. The stimulus first loads the pin's GPIO data and enable, then clears its ownership. It then drives A and B values that are the inverse of those latches, flips the select and checks that the pad follows only the selected peripheral. Open-drain is also combined with both GPIO and peripheral sources, to show that a driven 1 becomes a released pad.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int NATTR    = 7;   // ownership, oe, data, pull-up, open-drain, filter, select
  localparam int A_OWN    = 0;
  localparam int A_OE     = 1;
  localparam int A_DAT    = 2;
  localparam int A_PU     = 3;
  localparam int A_OD     = 4;
  localparam int A_FLT    = 5;
  localparam int A_SEL    = 6;
  localparam int LVL_ADDR = 3 * NATTR;  // 21

  // set address of attribute k
  function automatic int set_addr(input int k);
    return 3 * k;
  endfunction

  function automatic int clr_addr(input int k);
    return 3 * k + 1;
  endfunction

  function automatic int stat_addr(input int k);
    return 3 * k + 2;
  endfunction

  // reset level: ownership and pull-up start at 1
  function automatic bit attr_rst_one(input int k);
    return (k == A_OWN) || (k == A_PU);
  endfunction
endpackage

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
  parameter int           W   = 32,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST;
    else        q <= (q | set_i) & ~clr_i;
  end
endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux (
  input  logic own,
  input  logic sel_b,
  input  logic gp_oe,
  input  logic gp_dat,
  input  logic od,
  input  logic a_out,
  input  logic a_oe,
  input  logic b_out,
  input  logic b_oe,
  output logic pin_out,
  output logic pin_oe
);
  logic src_out, src_oe;
  always_comb begin
    if (own) begin
      src_out = gp_dat;
      src_oe  = gp_oe;
    end else if (sel_b) begin
      src_out = b_out;
      src_oe  = b_oe;
    end else begin
      src_out = a_out;
      src_oe  = a_oe;
    end
    if (od) begin
      pin_out = 1'b0;
      pin_oe  = src_oe & ~src_out;
    end else begin
      pin_out = src_out;
      pin_oe  = src_oe;
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_pu,
  output logic [NPINS-1:0]  pad_filt,
  input  logic [NPINS-1:0]  pa_out,
  input  logic [NPINS-1:0]  pa_oe,
  input  logic [NPINS-1:0]  pb_out,
  input  logic [NPINS-1:0]  pb_oe
);
  logic [NPINS-1:0] attr_q [NATTR];
  logic [NPINS-1:0] lvl_q;

  // one set/clear register per attribute
  for (genvar k = 0; k < NATTR; k++) begin : g_attr
    localparam logic [NPINS-1:0] RSTV = {NPINS{attr_rst_one(k)}};
    logic [NPINS-1:0] set_v, clr_v;
    assign set_v = (bus_wr && bus_addr == ADDR_W'(set_addr(k))) ? bus_wdata : '0;
    assign clr_v = (bus_wr && bus_addr == ADDR_W'(clr_addr(k))) ? bus_wdata : '0;
    gpio_setclr_reg #(.W(NPINS), .RST(RSTV)) u_reg (
      .clk(clk), .rst_n(rst_n), .set_i(set_v), .clr_i(clr_v), .q(attr_q[k])
    );
  end

  logic [NPINS-1:0] own_q, oe_q, dat_q, od_q, sel_q;
  assign own_q    = attr_q[A_OWN];
  assign oe_q     = attr_q[A_OE];
  assign dat_q    = attr_q[A_DAT];
  assign od_q     = attr_q[A_OD];
  assign sel_q    = attr_q[A_SEL];
  assign pad_pu   = attr_q[A_PU];
  assign pad_filt = attr_q[A_FLT];

  gpio_sync2 #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(lvl_q)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    gpio_pin_mux u_mux (
      .own(own_q[i]), .sel_b(sel_q[i]), .gp_oe(oe_q[i]), .gp_dat(dat_q[i]),
      .od(od_q[i]), .a_out(pa_out[i]), .a_oe(pa_oe[i]),
      .b_out(pb_out[i]), .b_oe(pb_oe[i]),
      .pin_out(pad_out[i]), .pin_oe(pad_oe[i])
    );
  end

  // status read: write-only and unmapped addresses return zero
  always_comb begin
    bus_rdata = '0;
    for (int k = 0; k < NATTR; k++) begin
      if (bus_addr == ADDR_W'(stat_addr(k))) bus_rdata = attr_q[k];
    end
    if (bus_addr == ADDR_W'(LVL_ADDR)) bus_rdata = lvl_q;
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NPINS-1:0]  bus_wdata,
  input logic [NPINS-1:0]  bus_rdata,
  input logic [NPINS-1:0]  pad_in,
  input logic [NPINS-1:0]  pad_out,
  input logic [NPINS-1:0]  pad_oe,
  input logic [NPINS-1:0]  own_q,
  input logic [NPINS-1:0]  dat_q,
  input logic [NPINS-1:0]  od_q
);
  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cyc <= '0;
    else if (cyc != 3) cyc <= cyc + 2'd1;
  end

  logic is_stat;
  always_comb begin
    is_stat = (bus_addr == ADDR_W'(LVL_ADDR));
    for (int k = 0; k < NATTR; k++)
      if (bus_addr == ADDR_W'(stat_addr(k))) is_stat = 1'b1;
  end

  p_dat_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(set_addr(A_DAT))) |=> dat_q == ($past(dat_q) | $past(bus_wdata)));

  p_dat_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(clr_addr(A_DAT))) |=> dat_q == ($past(dat_q) & ~$past(bus_wdata)));

  p_own_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(set_addr(A_OWN))) |=> own_q == ($past(own_q) | $past(bus_wdata)));

  p_own_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(own_q));

  p_od_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (od_q & pad_oe & pad_out) == '0);

  p_wo_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !is_stat |-> bus_rdata == '0);

  p_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 3 && bus_addr == ADDR_W'(LVL_ADDR)) |-> bus_rdata == $past(pad_in, 2));
endmodule

bind gpio_bank gpio_bank_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
  .pad_out(pad_out), .pad_oe(pad_oe), .own_q(own_q), .dat_q(dat_q), .od_q(od_q)
);

// File: tb/test_gpio_bank.sv
`timescale 1ns/1ps
module test_gpio_bank;
  localparam int NP = 32;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [NP-1:0] bus_wdata = '0, bus_rdata;
  logic [NP-1:0] pad_in = '0, pad_out, pad_oe, pad_pu, pad_filt;
  logic [NP-1:0] pa_out = '0, pa_oe = '0, pb_out = '0, pb_oe = '0;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  gpio_bank #(.NPINS(NP), .ADDR_W(AW)) i_gpio_bank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_filt(pad_filt),
    .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out), .pb_oe(pb_oe)
  );

  // write address, data, expected status after the write (status at base+2)
  localparam int NV = 14;
  localparam logic [AW-1:0] T_ADDR [NV] = '{
    5'd1, 5'd0, 5'd3, 5'd4, 5'd6, 5'd7, 5'd10,
    5'd9, 5'd12, 5'd13, 5'd15, 5'd18, 5'd19, 5'd16};
  localparam logic [NP-1:0] T_DATA [NV] = '{
    32'h0000_00FF, 32'h0000_000F, 32'hF0F0_0000, 32'h3000_0000,
    32'h0000_FFFF, 32'h0000_00F0, 32'hAAAA_AAAA, 32'h0000_000A,
    32'h0F00_0003, 32'h0000_0001, 32'h8000_0001, 32'h0000_00C0,
    32'h0000_0040, 32'h0000_0001};
  localparam logic [NP-1:0] T_EXP [NV] = '{
    32'hFFFF_FF00, 32'hFFFF_FF0F, 32'hF0F0_0000, 32'hC0F0_0000,
    32'h0000_FFFF, 32'h0000_FF0F, 32'h5555_5555, 32'h5555_555F,
    32'h0F00_0003, 32'h0F00_0002, 32'h8000_0001, 32'h0000_00C0,
    32'h0000_0080, 32'h8000_0000};

  task automatic chk(input string req, input logic [NP-1:0] got, input logic [NP-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [NP-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [NP-1:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin : watchdog
    #100000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [NP-1:0] v;
    do_reset();

    // R1 reset state
    rd(5'd2, v);  chk("R1 own", v, '1);
    rd(5'd5, v);  chk("R1 oe", v, '0);
    rd(5'd8, v);  chk("R1 dat", v, '0);
    rd(5'd11, v); chk("R1 pu", v, '1);
    rd(5'd14, v); chk("R1 od", v, '0);
    rd(5'd17, v); chk("R1 flt", v, '0);
    rd(5'd20, v); chk("R1 sel", v, '0);
    chk("R1 pad_pu", pad_pu, '1);
    chk("R1 pad_oe", pad_oe, '0);

    // R2 / R3 table walk
    for (int n = 0; n < NV; n++) begin
      wr(T_ADDR[n], T_DATA[n]);
      rd(AW'((int'(T_ADDR[n]) / 3) * 3 + 2), v);
      chk((T_ADDR[n] >= 5'd18) ? "R3 select" : "R2 set/clear", v, T_EXP[n]);
    end
    // R10 pull-up and filter pins follow the table state
    chk("R10 pad_pu", pad_pu, 32'h5555_555F);
    chk("R10 pad_filt", pad_filt, 32'h8000_0000);

    // R9 write-only and unmapped reads
    for (int a = 0; a < 32; a++) begin
      if (a % 3 != 2 && a != 21) begin
        rd(AW'(a), v);
        chk("R9 write-only read", v, '0);
      end
    end

    do_reset();
    // R8 data before enable
    wr(5'd6, 32'h1);
    chk("R8 no drive before oe", pad_oe & 32'h1, 32'h0);
    wr(5'd3, 32'h1);
    chk("R8 oe on", pad_oe & 32'h1, 32'h1);
    chk("R8 level on enable", pad_out & 32'h1, 32'h1);
    // R4 push-pull follows data
    wr(5'd7, 32'h1);
    chk("R4 drive low", pad_out & 32'h1, 32'h0);
    chk("R4 still enabled", pad_oe & 32'h1, 32'h1);
    // R5 open-drain
    wr(5'd12, 32'h1);
    chk("R5 od low drives", pad_oe & 32'h1, 32'h1);
    chk("R5 od out zero", pad_out & 32'h1, 32'h0);
    wr(5'd6, 32'h1);
    chk("R5 od high released", pad_oe & 32'h1, 32'h0);
    chk("R5 od out stays zero", pad_out & 32'h1, 32'h0);

    // R6 peripheral ownership of pin 4, GPIO latches oe=1 dat=1
    wr(5'd3, 32'h10);
    wr(5'd6, 32'h10);
    pa_out = 32'h0; pa_oe = 32'h10; pb_out = 32'h10; pb_oe = 32'h0;
    wr(5'd1, 32'h10);
    chk("R6 A out", pad_out & 32'h10, 32'h0);
    chk("R6 A oe", pad_oe & 32'h10, 32'h10);
    wr(5'd18, 32'h10);
    chk("R6 B oe", pad_oe & 32'h10, 32'h0);
    chk("R6 B out", pad_out & 32'h10, 32'h10);
    wr(5'd12, 32'h10);
    pb_oe = 32'h10; pb_out = 32'h0;
    #1;
    chk("R5 od on peripheral", pad_oe & 32'h10, 32'h10);

    // R7 level sync, pin 4 peripheral-owned
    rd(5'd21, v); chk("R7 level idle", v, '0);
    @(negedge clk);
    pad_in = 32'hA5A5_5A5A;
    bus_addr = 5'd21;
    @(negedge clk);
    chk("R7 not yet after one edge", bus_rdata, '0);
    @(negedge clk);
    chk("R7 after two edges", bus_rdata, 32'hA5A5_5A5A);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule